// File: doc/BRIEF.md
# Preferred-Path Switch Output Port

This block is a single output port of a buffered-crossbar mesh switch. Each input that can reach the port has its own small FIFO at this output. On top of that, one input is named as the preferred input. A flit that this input marks as eagerly forwarded goes straight through a combinational bypass to the output in the same cycle. It does not wait for arbitration.

When the preferred input is not driving a flit, a round-robin arbiter picks one of the eligible FIFOs. A FIFO is eligible when it holds a flit. An empty FIFO is also eligible when a flit is being written into it in the same cycle, and that flit then passes straight through.

Software-independent configuration logic can move the preferred input at run time. A configuration write is applied only in a cycle when the bypass carries no flit, so a flit on the bypass is never cut off by a reconfiguration. Each FIFO holds two flits by default. When a FIFO is full it lowers its ready signal, and the sender holds the flit until there is room.

Top module: `pp_out_port`

## Requirements
- R1: After reset, out_valid is 0 and every in_ready is 1. The preferred input is RST_PREF (default 0), the round-robin pointer is 0, and all FIFOs are empty.
- R2: When in_valid of the preferred input is 1, out_valid is 1 in the same cycle, out_flit equals that input's flit, and out_src equals its index.
- R3: in_valid of any input that is not the preferred one has no effect on the outputs.
- R4: While the bypass carries a flit, no FIFO is popped and FIFO contents are held. A FIFO may still accept a write in that cycle.
- R5: A FIFO is eligible when it is non-empty, or when in_enq and in_ready are both 1 for it in that cycle. An empty FIFO that is granted while being written forwards the incoming flit in the same cycle and stays empty.
- R6: With the bypass idle, the grant goes to the first eligible FIFO found by searching upward, with wrap-around, from the round-robin pointer. After a grant to index g, the pointer becomes (g+1) mod NUM_IN. The pointer is unchanged when nothing is granted.
- R7: Each FIFO delivers its flits in arrival order and holds up to DEPTH flits. in_ready is 0 exactly when the FIFO is full, and a request made while in_ready is 0 is not stored.
- R8: A write with cfg_we=1 sets the preferred input to cfg_pref from the next cycle on. The write is ignored when the bypass carries a flit in that cycle, and also when cfg_pref is NUM_IN or larger.
- R9: out_src gives the binary index of the input whose flit is on out_flit. It is meaningful only when out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_flit | input | NUM_IN*FLIT_W | Flit bus of every input, input i at bits [i*FLIT_W +: FLIT_W] |
| in_valid | input | NUM_IN | Eager-forward valid per input; only the preferred input's bit is used |
| in_enq | input | NUM_IN | Request to write the input's flit into its FIFO |
| in_ready | output | NUM_IN | FIFO has room for a flit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pref | input | $clog2(NUM_IN) | New preferred input index |
| out_valid | output | 1 | A flit is on out_flit |
| out_flit | output | FLIT_W | Output flit |
| out_src | output | $clog2(NUM_IN) | Index of the input that supplied out_flit |

## Verification
A wrong FIFO pointer or count shows at the output within the next grant of that FIFO: a flit appears out of order, twice, or not at all, or in_ready changes in the wrong cycle. A faulty round-robin pointer shows at once as the wrong out_src whenever two or more FIFOs are eligible. A preferred-input register that took a blocked or out-of-range write shows on the very next cycle that the old preferred input drives in_valid. The bench models FIFO contents, the pointer and the preferred index arithmetically. It compares every output in every cycle, so each of these faults is reported in the cycle where it first becomes visible.

// File: rtl/pp_out_port.sv
module pp_out_port #(
  parameter int NUM_IN   = 5,
  parameter int FLIT_W   = 39,
  parameter int DEPTH    = 2,
  parameter int RST_PREF = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_IN*FLIT_W-1:0] in_flit,
  input  logic [NUM_IN-1:0]        in_valid,
  input  logic [NUM_IN-1:0]        in_enq,
  output logic [NUM_IN-1:0]        in_ready,
  input  logic                     cfg_we,
  input  logic [$clog2(NUM_IN)-1:0] cfg_pref,
  output logic                     out_valid,
  output logic [FLIT_W-1:0]        out_flit,
  output logic [$clog2(NUM_IN)-1:0] out_src
);
  localparam int IW = $clog2(NUM_IN);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0] pref_q, rr_q, gidx;
  logic [NUM_IN-1:0][CW-1:0] cnt_q;
  logic [NUM_IN-1:0][FLIT_W-1:0] head;
  logic [NUM_IN-1:0] elig, grant, push;
  logic found, bypass;

  assign bypass = in_valid[pref_q];

  for (genvar i = 0; i < NUM_IN; i++) begin : g_q
    logic [FLIT_W-1:0] mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [FLIT_W-1:0] din;
    logic empty;

    assign din         = in_flit[i*FLIT_W +: FLIT_W];
    assign empty       = (cnt_q[i] == '0);
    assign in_ready[i] = (cnt_q[i] < CW'(DEPTH));
    assign push[i]     = in_enq[i] & in_ready[i];
    assign elig[i]     = !empty | push[i];
    assign head[i]     = empty ? din : mem[rd_q];

    always_ff @(posedge clk)
      if (push[i] && !(grant[i] && empty)) mem[wr_q] <= din;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0;
        rd_q     <= '0;
        wr_q     <= '0;
      end else begin
        cnt_q[i] <= cnt_q[i] + CW'(push[i]) - CW'(grant[i]);
        if (push[i] && !(grant[i] && empty))
          wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
        if (grant[i] && !empty)
          rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
    end
  end

  always_comb begin
    grant = '0;
    found = 1'b0;
    gidx  = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      int j;
      j = int'(rr_q) + k;
      if (j >= NUM_IN) j = j - NUM_IN;
      if (!found && !bypass && elig[j]) begin
        grant[j] = 1'b1;
        found    = 1'b1;
        gidx     = IW'(j);
      end
    end
  end

  assign out_valid = bypass | found;
  assign out_flit  = bypass ? in_flit[pref_q*FLIT_W +: FLIT_W] : head[gidx];
  assign out_src   = bypass ? pref_q : gidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pref_q <= IW'(RST_PREF);
      rr_q   <= '0;
    end else begin
      if (found)
        rr_q <= (gidx == IW'(NUM_IN - 1)) ? '0 : gidx + 1'b1;
      if (cfg_we && !bypass && (int'(cfg_pref) < NUM_IN))
        pref_q <= cfg_pref;
    end
  end
endmodule

// File: rtl/pp_out_port_chk.sv
module pp_out_port_chk #(
  parameter int NUM_IN = 5,
  parameter int DEPTH  = 2,
  parameter int IW     = 3,
  parameter int CW     = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_IN-1:0]        in_valid,
  input logic [NUM_IN-1:0]        in_ready,
  input logic                     out_valid,
  input logic [IW-1:0]            out_src,
  input logic [IW-1:0]            pref,
  input logic [NUM_IN-1:0][CW-1:0] cnt,
  input logic [NUM_IN-1:0]        grant,
  input logic                     cfg_we
);
  AST_BYPASS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[pref] |-> (out_valid && out_src == pref)); // R2
  AST_BYPASS_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid[pref] |-> (grant == '0)); // R4
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_GRANT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (out_valid && grant[out_src])); // R9
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && in_valid[pref]) |=> $stable(pref)); // R8
  AST_PREF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pref) < NUM_IN); // R8

  for (genvar i = 0; i < NUM_IN; i++) begin : g_a
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt[i]) <= DEPTH); // R7
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cnt[i]) == DEPTH) |-> !in_ready[i]); // R7
  end
endmodule

bind pp_out_port pp_out_port_chk #(
  .NUM_IN(NUM_IN), .DEPTH(DEPTH), .IW(IW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_src(out_src), .pref(pref_q), .cnt(cnt_q),
  .grant(grant), .cfg_we(cfg_we)
);

// File: tb/pp_out_port_tb.sv
module pp_out_port_tb;
  localparam int N = 5;
  localparam int W = 39;
  localparam int D = 2;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*W-1:0] in_flit = '0;
  logic [N-1:0] in_valid = '0, in_enq = '0, in_ready;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_pref = '0;
  logic out_valid;
  logic [W-1:0] out_flit;
  logic [IW-1:0] out_src;

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] q [N][D];
  int qc [N];
  int pref, rr;
  bit prev_cfg, prev_hold;

  always #2 clk = ~clk;

  pp_out_port #(.NUM_IN(N), .FLIT_W(W), .DEPTH(D), .RST_PREF(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_valid(in_valid),
    .in_enq(in_enq), .in_ready(in_ready), .cfg_we(cfg_we), .cfg_pref(cfg_pref),
    .out_valid(out_valid), .out_flit(out_flit), .out_src(out_src));

  task automatic check(string tag, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus, check outputs against the model, advance model.
  task automatic step(int p_valid, int p_enq, int p_cfg);
    bit bp, found;
    int g;
    logic [W-1:0] ef;
    string tag;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_flit[i*W +: W] = {3'(i), 32'($urandom), 4'h5};
      in_valid[i] = (($urandom % 100) < p_valid);
      in_enq[i]   = (($urandom % 100) < p_enq);
    end
    cfg_we   = (($urandom % 100) < p_cfg);
    cfg_pref = IW'($urandom % 8);
    #1;
    bp = in_valid[pref];
    found = 0; g = 0;
    if (!bp)
      for (int k = 0; k < N; k++) begin
        int j;
        j = (rr + k) % N;
        if (!found && (qc[j] > 0 || (in_enq[j] && qc[j] < D))) begin
          found = 1; g = j;
        end
      end
    if (bp) ef = in_flit[pref*W +: W];
    else if (found) ef = (qc[g] > 0) ? q[g][0] : in_flit[g*W +: W];
    else ef = '0;
    // R3 when non-preferred valids present, R8 right after a config write, R4 after a blocked pop
    tag = bp ? "R2" : (prev_cfg ? "R8" : (prev_hold ? "R4" : ((in_valid != 0) ? "R3" : "R6")));
    check(tag, "out_valid", out_valid, bp | found);
    if (bp | found) begin
      check(bp ? tag : "R6", "out_src R9", out_src, bp ? pref : g);
      check(bp ? tag : ((found && qc[g] == 0) ? "R5" : "R7"), "out_flit", out_flit, ef);
    end
    for (int i = 0; i < N; i++)
      check("R7", "in_ready", in_ready[i], qc[i] < D);
    prev_hold = 0;
    for (int i = 0; i < N; i++) begin
      if (bp && qc[i] > 0) prev_hold = 1;
      if (in_enq[i] && qc[i] < D) begin q[i][qc[i]] = in_flit[i*W +: W]; qc[i]++; end
    end
    if (found) begin
      for (int s = 0; s < D - 1; s++) q[g][s] = q[g][s+1];
      qc[g]--;
      rr = (g + 1) % N;
    end
    prev_cfg = cfg_we;
    if (cfg_we && !bp && int'(cfg_pref) < N) pref = int'(cfg_pref);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) qc[i] = 0;
    pref = 0; rr = 0; prev_cfg = 0; prev_hold = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state
    check("R1", "out_valid", out_valid, 0);
    check("R1", "in_ready", in_ready, {N{1'b1}});
    // R1: every FIFO empty and enqueuing, pointer 0 -> input 0 passes through
    @(negedge clk);
    for (int i = 0; i < N; i++) in_flit[i*W +: W] = {3'(i), 36'h123};
    in_enq = '1; #1;
    check("R1", "out_src", out_src, 0);
    check("R5", "out_flit pass-through", out_flit, {3'd0, 36'h123});
    for (int i = 1; i < N; i++) begin q[i][0] = in_flit[i*W +: W]; qc[i] = 1; end
    rr = 1;
    @(negedge clk); in_enq = '0;
    // drain in round-robin order 1..4
    for (int i = 1; i < N; i++) begin
      #1;
      check("R6", "rr order", out_src, i);
      check("R7", "flit", out_flit, q[i][0]);
      qc[i] = 0;
      @(negedge clk);
    end
    rr = 0;
    #1; check("R6", "idle out_valid", out_valid, 0);
    // sweeps with varied traffic density
    for (int pv = 0; pv <= 60; pv += 20)
      for (int pe = 10; pe <= 90; pe += 40)
        repeat (300) step(pv, pe, 15);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule